// File: doc/BRIEF.md
# Register Dependency Scoreboard

This block keeps, for every architectural register of an in-order pipeline, a short ordered queue of the sequence numbers of in-flight instructions that will write that register. An instruction enters the queue of each of its destination registers when it issues. It leaves the head of a queue when it writes back. On a squash it is taken out of its queues wherever it sits. Every entry also carries an executed flag and a result-ready flag. The ready flag rises one cycle after the executed flag.

Combinational lookups answer four questions about a register:
- May an instruction with a given sequence number read it?
- May that instruction write it?
- Which older producer, if any, can forward its result?
- Which entry behind the head has already executed and could bypass?

An occupancy lookup reports how many writers are pending on a register. Sequence numbers are 8 bits wide and wrap. Ordering uses modular subtraction and assumes fewer than 128 instructions in flight.

Each register queue is a small state machine with three states: Q_EMPTY, Q_PARTIAL and Q_FULL.
- Q_EMPTY goes to Q_PARTIAL on an accepted insert.
- Q_PARTIAL goes to Q_FULL when the insert fills the last slot.
- Q_PARTIAL goes back to Q_EMPTY when a removal takes the last entry.
- Q_FULL goes to Q_PARTIAL on any removal.
- A clear sends every queue to Q_EMPTY from any state.

Within one cycle a queue applies its updates in this order: execute marking, head removal, removal by identity, then insert. Clear overrides all of them.

Top module: `sbd_scoreboard`

## Requirements
- R1: An accepted insert appends the sequence number at the tail of the queue of every enabled destination register, so queue order equals issue order. When both destination indices name the same register, that register receives one entry.
- R2: `rd_ok_o` is 1 when the selected register's queue is empty, or when `rd_seq_i` is not after the head's sequence number. Otherwise it is 0.
- R3: `wr_ok_o` follows the same rule as R2, using `wr_reg_i` and `wr_seq_i`.
- R4: The forward lookup walks the queue from the head. It takes the last entry in the unbroken run of entries strictly older than `fw_seq_i`. `fw_seq_o` reports that entry's sequence number on a hit and 0 otherwise.
- R5: A forward hit needs the chosen entry's executed and result-ready flags both set. An execute pulse on `ex_seq_i`, taken at clock edge k, marks every queued entry carrying that number as executed at edge k. The entry becomes ready at edge k+1. So `fw_hit_o` first rises after edge k+1.
- R6: A writeback removes the head of `wb_reg_i`'s queue only when the head's sequence number equals `wb_seq_i`. A mismatching writeback leaves the queue unchanged.
- R7: A squash deletes, from each enabled destination register's queue, the first entry that equals `sq_seq_i`. The remaining entries close up and keep their order. A number that is absent changes nothing.
- R8: `by_hit_o` is 0 when the queue of `by_reg_i` holds fewer than two entries. Otherwise it reports the first executed entry after the head, giving its number on `by_seq_o`.
- R9: `clear_i` empties every queue at the next edge and overrides any insert, writeback, squash or execute in the same cycle.
- R10: `ins_stall_o` is high when `ins_valid_i` is set and any enabled destination queue holds DEPTH entries before this cycle's removals. A stalled insert adds nothing to any queue.
- R11: Sequence a is older than b when the 8-bit difference a minus b has its top bit set. For example, 250 is older than 3, and 3 is not older than 250.
- R12: After reset every queue is empty. `occ_cnt_o` reports the entry count of the queue selected by `occ_reg_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| clear_i | input | 1 | Empty all queues |
| ins_valid_i | input | 1 | Insert request |
| ins_seq_i | input | 8 | Sequence number being inserted |
| ins_d0_en_i | input | 1 | First destination valid |
| ins_d0_i | input | 3 | First destination register |
| ins_d1_en_i | input | 1 | Second destination valid |
| ins_d1_i | input | 3 | Second destination register |
| ins_stall_o | output | 1 | Insert refused, a target queue is full |
| wb_valid_i | input | 1 | Writeback head removal request |
| wb_reg_i | input | 3 | Register written back |
| wb_seq_i | input | 8 | Sequence number writing back |
| sq_valid_i | input | 1 | Squash removal request |
| sq_seq_i | input | 8 | Sequence number squashed |
| sq_d0_en_i | input | 1 | First squash destination valid |
| sq_d0_i | input | 3 | First squash destination register |
| sq_d1_en_i | input | 1 | Second squash destination valid |
| sq_d1_i | input | 3 | Second squash destination register |
| ex_valid_i | input | 1 | Execute completion pulse |
| ex_seq_i | input | 8 | Sequence number that executed |
| rd_reg_i | input | 3 | Read lookup register |
| rd_seq_i | input | 8 | Read lookup requester |
| rd_ok_o | output | 1 | Read allowed |
| wr_reg_i | input | 3 | Write lookup register |
| wr_seq_i | input | 8 | Write lookup requester |
| wr_ok_o | output | 1 | Write allowed |
| fw_reg_i | input | 3 | Forward lookup register |
| fw_seq_i | input | 8 | Forward lookup requester |
| fw_hit_o | output | 1 | Forward source available |
| fw_seq_o | output | 8 | Forward source sequence number |
| by_reg_i | input | 3 | Bypass lookup register |
| by_hit_o | output | 1 | Bypass entry found |
| by_seq_o | output | 8 | Bypass entry sequence number |
| occ_reg_i | input | 3 | Occupancy lookup register |
| occ_cnt_o | output | 3 | Entries pending on that register |

## Verification
The bench targets the following corner cases:
- **Forwarding timing.** It probes the forward lookup in the cycle after an execute pulse and again one cycle later. A design that treated executed as ready would forward one cycle early.
- **Forwarding choice.** It asks for a requester that sits between two queued writers. A design that picked the oldest older entry, or any entry regardless of age, would name the wrong producer.
- **Squash and compaction.** It squashes a middle entry and then checks forwarding and bypass across the gap. A design that did not compact, or that reordered entries, would report the deleted or misplaced producer.
- **Writeback, stall, clear and wrap.** It checks a mismatching writeback, and an insert into a full queue in the same cycle as a writeback. It checks a clear racing an insert. It checks reads across the 8-bit wrap, where a plain magnitude compare gives the opposite answer.
- **Sweep.** A sweep over every register fills each queue to depth and drains it in order.

// File: rtl/sbd_pkg.sv
package sbd_pkg;

    localparam int SEQ_W = 8;

    typedef logic [SEQ_W-1:0] seq_t;

    typedef enum logic [1:0] {
        Q_EMPTY   = 2'd0,
        Q_PARTIAL = 2'd1,
        Q_FULL    = 2'd2
    } qstate_e;

    // a strictly older than b, modulo 2**SEQ_W (window under half the range)
    function automatic logic seq_before(input seq_t a, input seq_t b);
        seq_t diff;
        diff = a - b;
        return diff[SEQ_W-1];
    endfunction

    function automatic logic seq_not_after(input seq_t a, input seq_t b);
        return (a == b) || seq_before(a, b);
    endfunction

endpackage

// File: rtl/sbd_queue.sv
module sbd_queue
    import sbd_pkg::*;
#(
    parameter int DEPTH = 4,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  clear_i,
    input  logic                  push_en_i,
    input  seq_t                  push_seq_i,
    input  logic                  pop_en_i,
    input  seq_t                  pop_seq_i,
    input  logic                  kill_en_i,
    input  seq_t                  kill_seq_i,
    input  logic                  exec_en_i,
    input  seq_t                  exec_seq_i,
    output seq_t [DEPTH-1:0]      seq_o,
    output logic [DEPTH-1:0]      exe_o,
    output logic [DEPTH-1:0]      rdy_o,
    output logic [CW-1:0]         cnt_o,
    output logic                  full_o
);

    localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);
    localparam logic [CW-1:0] ONE      = CW'(1);

    qstate_e               state_q, state_d;
    seq_t [DEPTH-1:0]      seq_q, seq_d;
    logic [DEPTH-1:0]      exe_q, exe_d;
    logic [DEPTH-1:0]      rdy_q, rdy_d;
    logic [CW-1:0]         cnt_q, cnt_d;

    // Next contents: execute mark, head pop, kill by identity, push; clear wins
    always_comb begin : next_contents
        logic kill_hit;
        int   kill_pos;
        kill_hit = 1'b0;
        kill_pos = 0;
        seq_d    = seq_q;
        exe_d    = exe_q;
        rdy_d    = rdy_q | exe_q;
        cnt_d    = cnt_q;

        if (exec_en_i) begin
            for (int i = 0; i < DEPTH; i++) begin
                if (CW'(i) < cnt_q && seq_q[i] == exec_seq_i) begin
                    exe_d[i] = 1'b1;
                end
            end
        end

        if (pop_en_i && cnt_d != '0 && seq_d[0] == pop_seq_i) begin
            for (int i = 0; i < DEPTH - 1; i++) begin
                seq_d[i] = seq_d[i+1];
                exe_d[i] = exe_d[i+1];
                rdy_d[i] = rdy_d[i+1];
            end
            seq_d[DEPTH-1] = '0;
            exe_d[DEPTH-1] = 1'b0;
            rdy_d[DEPTH-1] = 1'b0;
            cnt_d = cnt_d - ONE;
        end

        if (kill_en_i) begin
            for (int i = 0; i < DEPTH; i++) begin
                if (!kill_hit && CW'(i) < cnt_d && seq_d[i] == kill_seq_i) begin
                    kill_hit = 1'b1;
                    kill_pos = i;
                end
            end
            if (kill_hit) begin
                for (int i = 0; i < DEPTH - 1; i++) begin
                    if (i >= kill_pos) begin
                        seq_d[i] = seq_d[i+1];
                        exe_d[i] = exe_d[i+1];
                        rdy_d[i] = rdy_d[i+1];
                    end
                end
                seq_d[DEPTH-1] = '0;
                exe_d[DEPTH-1] = 1'b0;
                rdy_d[DEPTH-1] = 1'b0;
                cnt_d = cnt_d - ONE;
            end
        end

        if (push_en_i && cnt_d < FULL_CNT) begin
            for (int i = 0; i < DEPTH; i++) begin
                if (CW'(i) == cnt_d) begin
                    seq_d[i] = push_seq_i;
                    exe_d[i] = 1'b0;
                    rdy_d[i] = 1'b0;
                end
            end
            cnt_d = cnt_d + ONE;
        end

        if (clear_i) begin
            seq_d = '0;
            exe_d = '0;
            rdy_d = '0;
            cnt_d = '0;
        end
    end

    // Next occupancy state
    always_comb begin : next_state
        if (cnt_d == '0) begin
            state_d = Q_EMPTY;
        end else if (cnt_d == FULL_CNT) begin
            state_d = Q_FULL;
        end else begin
            state_d = Q_PARTIAL;
        end
    end

    // State and contents registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= Q_EMPTY;
            seq_q   <= '0;
            exe_q   <= '0;
            rdy_q   <= '0;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            seq_q   <= seq_d;
            exe_q   <= exe_d;
            rdy_q   <= rdy_d;
            cnt_q   <= cnt_d;
        end
    end

    // Outputs from state
    always_comb begin : state_outputs
        unique case (state_q)
            Q_EMPTY:   full_o = 1'b0;
            Q_PARTIAL: full_o = 1'b0;
            Q_FULL:    full_o = 1'b1;
            default:   full_o = 1'b0;
        endcase
    end

    assign seq_o = seq_q;
    assign exe_o = exe_q;
    assign rdy_o = rdy_q;
    assign cnt_o = cnt_q;

endmodule

// File: rtl/sbd_order_gate.sv
module sbd_order_gate
    import sbd_pkg::*;
#(
    parameter int CW = 3
) (
    input  logic [CW-1:0] cnt_i,
    input  seq_t          head_i,
    input  seq_t          req_i,
    output logic          ok_o
);

    // Free when nobody is pending, or when the requester is not younger than the head
    always_comb begin
        ok_o = (cnt_i == '0) || seq_not_after(req_i, head_i);
    end

endmodule

// File: rtl/sbd_fwd_pick.sv
module sbd_fwd_pick
    import sbd_pkg::*;
#(
    parameter int DEPTH = 4,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic [CW-1:0]         cnt_i,
    input  seq_t [DEPTH-1:0]      seq_i,
    input  logic [DEPTH-1:0]      exe_i,
    input  logic [DEPTH-1:0]      rdy_i,
    input  seq_t                  req_i,
    output logic                  hit_o,
    output seq_t                  seq_o
);

    always_comb begin
        logic found, stop, usable;
        seq_t pick;
        found  = 1'b0;
        stop   = 1'b0;
        usable = 1'b0;
        pick   = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (!stop && CW'(i) < cnt_i) begin
                if (seq_before(seq_i[i], req_i)) begin
                    found  = 1'b1;
                    pick   = seq_i[i];
                    usable = exe_i[i] & rdy_i[i];
                end else begin
                    stop = 1'b1;
                end
            end
        end
        hit_o = found && usable;
        seq_o = (found && usable) ? pick : '0;
    end

endmodule

// File: rtl/sbd_bypass_pick.sv
module sbd_bypass_pick
    import sbd_pkg::*;
#(
    parameter int DEPTH = 4,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic [CW-1:0]         cnt_i,
    input  seq_t [DEPTH-1:0]      seq_i,
    input  logic [DEPTH-1:0]      exe_i,
    output logic                  hit_o,
    output seq_t                  seq_o
);

    // First executed entry behind the head; a lone head never qualifies
    always_comb begin
        hit_o = 1'b0;
        seq_o = '0;
        for (int i = 1; i < DEPTH; i++) begin
            if (!hit_o && CW'(i) < cnt_i && exe_i[i]) begin
                hit_o = 1'b1;
                seq_o = seq_i[i];
            end
        end
    end

endmodule

// File: rtl/sbd_scoreboard.sv
module sbd_scoreboard
    import sbd_pkg::*;
#(
    parameter int NREG  = 8,
    parameter int DEPTH = 4,
    localparam int RIDX = $clog2(NREG),
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear_i,
    input  logic             ins_valid_i,
    input  logic [SEQ_W-1:0] ins_seq_i,
    input  logic             ins_d0_en_i,
    input  logic [RIDX-1:0]  ins_d0_i,
    input  logic             ins_d1_en_i,
    input  logic [RIDX-1:0]  ins_d1_i,
    output logic             ins_stall_o,
    input  logic             wb_valid_i,
    input  logic [RIDX-1:0]  wb_reg_i,
    input  logic [SEQ_W-1:0] wb_seq_i,
    input  logic             sq_valid_i,
    input  logic [SEQ_W-1:0] sq_seq_i,
    input  logic             sq_d0_en_i,
    input  logic [RIDX-1:0]  sq_d0_i,
    input  logic             sq_d1_en_i,
    input  logic [RIDX-1:0]  sq_d1_i,
    input  logic             ex_valid_i,
    input  logic [SEQ_W-1:0] ex_seq_i,
    input  logic [RIDX-1:0]  rd_reg_i,
    input  logic [SEQ_W-1:0] rd_seq_i,
    output logic             rd_ok_o,
    input  logic [RIDX-1:0]  wr_reg_i,
    input  logic [SEQ_W-1:0] wr_seq_i,
    output logic             wr_ok_o,
    input  logic [RIDX-1:0]  fw_reg_i,
    input  logic [SEQ_W-1:0] fw_seq_i,
    output logic             fw_hit_o,
    output logic [SEQ_W-1:0] fw_seq_o,
    input  logic [RIDX-1:0]  by_reg_i,
    output logic             by_hit_o,
    output logic [SEQ_W-1:0] by_seq_o,
    input  logic [RIDX-1:0]  occ_reg_i,
    output logic [CW-1:0]    occ_cnt_o
);

    seq_t [DEPTH-1:0]  q_seq [NREG];
    logic [DEPTH-1:0]  q_exe [NREG];
    logic [DEPTH-1:0]  q_rdy [NREG];
    logic [CW-1:0]     q_cnt [NREG];
    logic [NREG-1:0]   q_full;
    logic [NREG-1:0]   push_en, pop_en, kill_en;

    // Any enabled target already full refuses the whole insert
    assign ins_stall_o = ins_valid_i &&
                         ((ins_d0_en_i && q_full[ins_d0_i]) ||
                          (ins_d1_en_i && q_full[ins_d1_i]));

    for (genvar g = 0; g < NREG; g++) begin : g_reg
        localparam logic [RIDX-1:0] IDX = RIDX'(g);

        assign push_en[g] = ins_valid_i && !ins_stall_o &&
                            ((ins_d0_en_i && ins_d0_i == IDX) ||
                             (ins_d1_en_i && ins_d1_i == IDX));
        assign pop_en[g]  = wb_valid_i && (wb_reg_i == IDX);
        assign kill_en[g] = sq_valid_i &&
                            ((sq_d0_en_i && sq_d0_i == IDX) ||
                             (sq_d1_en_i && sq_d1_i == IDX));

        sbd_queue #(.DEPTH(DEPTH)) u_queue (
            .clk        (clk),
            .rst_n      (rst_n),
            .clear_i    (clear_i),
            .push_en_i  (push_en[g]),
            .push_seq_i (ins_seq_i),
            .pop_en_i   (pop_en[g]),
            .pop_seq_i  (wb_seq_i),
            .kill_en_i  (kill_en[g]),
            .kill_seq_i (sq_seq_i),
            .exec_en_i  (ex_valid_i),
            .exec_seq_i (ex_seq_i),
            .seq_o      (q_seq[g]),
            .exe_o      (q_exe[g]),
            .rdy_o      (q_rdy[g]),
            .cnt_o      (q_cnt[g]),
            .full_o     (q_full[g])
        );
    end

    sbd_order_gate #(.CW(CW)) u_rd_gate (
        .cnt_i  (q_cnt[rd_reg_i]),
        .head_i (q_seq[rd_reg_i][0]),
        .req_i  (rd_seq_i),
        .ok_o   (rd_ok_o)
    );

    sbd_order_gate #(.CW(CW)) u_wr_gate (
        .cnt_i  (q_cnt[wr_reg_i]),
        .head_i (q_seq[wr_reg_i][0]),
        .req_i  (wr_seq_i),
        .ok_o   (wr_ok_o)
    );

    sbd_fwd_pick #(.DEPTH(DEPTH)) u_fwd (
        .cnt_i (q_cnt[fw_reg_i]),
        .seq_i (q_seq[fw_reg_i]),
        .exe_i (q_exe[fw_reg_i]),
        .rdy_i (q_rdy[fw_reg_i]),
        .req_i (fw_seq_i),
        .hit_o (fw_hit_o),
        .seq_o (fw_seq_o)
    );

    sbd_bypass_pick #(.DEPTH(DEPTH)) u_byp (
        .cnt_i (q_cnt[by_reg_i]),
        .seq_i (q_seq[by_reg_i]),
        .exe_i (q_exe[by_reg_i]),
        .hit_o (by_hit_o),
        .seq_o (by_seq_o)
    );

    assign occ_cnt_o = q_cnt[occ_reg_i];

endmodule

// File: rtl/sbd_checker.sv
module sbd_checker
    import sbd_pkg::*;
#(
    parameter int NREG  = 8,
    parameter int DEPTH = 4,
    localparam int RIDX = $clog2(NREG),
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             clear_i,
    input logic             ins_valid_i,
    input logic             ins_d0_en_i,
    input logic [RIDX-1:0]  ins_d0_i,
    input logic             ins_stall_o,
    input logic [RIDX-1:0]  rd_reg_i,
    input logic             rd_ok_o,
    input logic [SEQ_W-1:0] fw_seq_i,
    input logic             fw_hit_o,
    input logic [SEQ_W-1:0] fw_seq_o,
    input logic [RIDX-1:0]  by_reg_i,
    input logic             by_hit_o,
    input logic [CW-1:0]    q_cnt [NREG]
);

    localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);
    localparam logic [CW-1:0] TWO      = CW'(2);

    p_stall_full_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (ins_valid_i && ins_d0_en_i && q_cnt[ins_d0_i] == FULL_CNT) |-> ins_stall_o);

    p_empty_read_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (q_cnt[rd_reg_i] == '0) |-> rd_ok_o);

    p_fwd_older_r4: assert property (@(posedge clk) disable iff (!rst_n)
        fw_hit_o |-> seq_before(fw_seq_o, fw_seq_i));

    p_bypass_two_r8: assert property (@(posedge clk) disable iff (!rst_n)
        by_hit_o |-> (q_cnt[by_reg_i] >= TWO));

    for (genvar g = 0; g < NREG; g++) begin : g_chk
        p_no_overflow_r1: assert property (@(posedge clk) disable iff (!rst_n)
            q_cnt[g] <= FULL_CNT);

        p_clear_empties_r9: assert property (@(posedge clk) disable iff (!rst_n)
            clear_i |=> (q_cnt[g] == '0));
    end

endmodule

bind sbd_scoreboard sbd_checker #(.NREG(NREG), .DEPTH(DEPTH)) u_sbd_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .clear_i     (clear_i),
    .ins_valid_i (ins_valid_i),
    .ins_d0_en_i (ins_d0_en_i),
    .ins_d0_i    (ins_d0_i),
    .ins_stall_o (ins_stall_o),
    .rd_reg_i    (rd_reg_i),
    .rd_ok_o     (rd_ok_o),
    .fw_seq_i    (fw_seq_i),
    .fw_hit_o    (fw_hit_o),
    .fw_seq_o    (fw_seq_o),
    .by_reg_i    (by_reg_i),
    .by_hit_o    (by_hit_o),
    .q_cnt       (q_cnt)
);

// File: tb/tb_sbd_scoreboard.sv
`timescale 1ns/1ps
module tb_sbd_scoreboard;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       clear_i;
    logic       ins_valid_i, ins_d0_en_i, ins_d1_en_i;
    logic [7:0] ins_seq_i;
    logic [2:0] ins_d0_i, ins_d1_i;
    logic       ins_stall_o;
    logic       wb_valid_i;
    logic [2:0] wb_reg_i;
    logic [7:0] wb_seq_i;
    logic       sq_valid_i, sq_d0_en_i, sq_d1_en_i;
    logic [7:0] sq_seq_i;
    logic [2:0] sq_d0_i, sq_d1_i;
    logic       ex_valid_i;
    logic [7:0] ex_seq_i;
    logic [2:0] rd_reg_i, wr_reg_i, fw_reg_i, by_reg_i, occ_reg_i;
    logic [7:0] rd_seq_i, wr_seq_i, fw_seq_i;
    logic       rd_ok_o, wr_ok_o, fw_hit_o, by_hit_o;
    logic [7:0] fw_seq_o, by_seq_o;
    logic [2:0] occ_cnt_o;

    int nchecks = 0;
    int nfail   = 0;
    bit done    = 1'b0;

    always #2.5 clk = ~clk;

    sbd_scoreboard #(.NREG(8), .DEPTH(4)) dut (
        .clk(clk), .rst_n(rst_n), .clear_i(clear_i),
        .ins_valid_i(ins_valid_i), .ins_seq_i(ins_seq_i),
        .ins_d0_en_i(ins_d0_en_i), .ins_d0_i(ins_d0_i),
        .ins_d1_en_i(ins_d1_en_i), .ins_d1_i(ins_d1_i), .ins_stall_o(ins_stall_o),
        .wb_valid_i(wb_valid_i), .wb_reg_i(wb_reg_i), .wb_seq_i(wb_seq_i),
        .sq_valid_i(sq_valid_i), .sq_seq_i(sq_seq_i),
        .sq_d0_en_i(sq_d0_en_i), .sq_d0_i(sq_d0_i),
        .sq_d1_en_i(sq_d1_en_i), .sq_d1_i(sq_d1_i),
        .ex_valid_i(ex_valid_i), .ex_seq_i(ex_seq_i),
        .rd_reg_i(rd_reg_i), .rd_seq_i(rd_seq_i), .rd_ok_o(rd_ok_o),
        .wr_reg_i(wr_reg_i), .wr_seq_i(wr_seq_i), .wr_ok_o(wr_ok_o),
        .fw_reg_i(fw_reg_i), .fw_seq_i(fw_seq_i), .fw_hit_o(fw_hit_o), .fw_seq_o(fw_seq_o),
        .by_reg_i(by_reg_i), .by_hit_o(by_hit_o), .by_seq_o(by_seq_o),
        .occ_reg_i(occ_reg_i), .occ_cnt_o(occ_cnt_o)
    );

    task automatic chk(input string req, input int act, input int exp);
        nchecks++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic idle();
        clear_i = 0; ins_valid_i = 0; ins_d0_en_i = 0; ins_d1_en_i = 0;
        ins_seq_i = 0; ins_d0_i = 0; ins_d1_i = 0;
        wb_valid_i = 0; wb_reg_i = 0; wb_seq_i = 0;
        sq_valid_i = 0; sq_seq_i = 0; sq_d0_en_i = 0; sq_d1_en_i = 0; sq_d0_i = 0; sq_d1_i = 0;
        ex_valid_i = 0; ex_seq_i = 0;
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
        idle();
    endtask

    task automatic set_ins(input int s, input bit e0, input int d0, input bit e1, input int d1);
        ins_valid_i = 1; ins_seq_i = 8'(s);
        ins_d0_en_i = e0; ins_d0_i = 3'(d0);
        ins_d1_en_i = e1; ins_d1_i = 3'(d1);
    endtask

    task automatic do_ins(input int s, input bit e0, input int d0, input bit e1, input int d1);
        set_ins(s, e0, d0, e1, d1);
        tick();
    endtask

    task automatic do_wb(input int r, input int s);
        wb_valid_i = 1; wb_reg_i = 3'(r); wb_seq_i = 8'(s);
        tick();
    endtask

    task automatic do_sq(input int s, input bit e0, input int d0, input bit e1, input int d1);
        sq_valid_i = 1; sq_seq_i = 8'(s);
        sq_d0_en_i = e0; sq_d0_i = 3'(d0); sq_d1_en_i = e1; sq_d1_i = 3'(d1);
        tick();
    endtask

    task automatic do_ex(input int s);
        ex_valid_i = 1; ex_seq_i = 8'(s);
        tick();
    endtask

    task automatic chk_occ(input string req, input int r, input int exp);
        occ_reg_i = 3'(r); #0.2;
        chk(req, int'(occ_cnt_o), exp);
    endtask

    task automatic chk_rd(input string req, input int r, input int s, input int exp);
        rd_reg_i = 3'(r); rd_seq_i = 8'(s); #0.2;
        chk(req, int'(rd_ok_o), exp);
    endtask

    task automatic chk_wr(input string req, input int r, input int s, input int exp);
        wr_reg_i = 3'(r); wr_seq_i = 8'(s); #0.2;
        chk(req, int'(wr_ok_o), exp);
    endtask

    task automatic chk_fw(input string req, input int r, input int s, input int eh, input int es);
        fw_reg_i = 3'(r); fw_seq_i = 8'(s); #0.2;
        chk(req, int'(fw_hit_o), eh);
        chk(req, int'(fw_seq_o), es);
    endtask

    task automatic chk_by(input string req, input int r, input int eh, input int es);
        by_reg_i = 3'(r); #0.2;
        chk(req, int'(by_hit_o), eh);
        chk(req, int'(by_seq_o), es);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            nfail++;
            nchecks++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", nchecks, nfail);
            $finish;
        end
    end

    initial begin
        idle();
        rd_reg_i = 0; rd_seq_i = 0; wr_reg_i = 0; wr_seq_i = 0;
        fw_reg_i = 0; fw_seq_i = 0; by_reg_i = 0; occ_reg_i = 0;
        rst_n = 0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1;

        // R12 reset state: every queue empty, every lookup idle
        for (int r = 0; r < 8; r++) begin
            chk_occ("R12 reset occupancy", r, 0);
            chk_rd("R2 empty read", r, 77, 1);
            chk_by("R8 empty bypass", r, 0, 0);
        end

        // R1 multi-destination and duplicate-index insert
        do_ins(10, 1, 1, 1, 2);
        chk_occ("R1 dest0 appended", 1, 1);
        chk_occ("R1 dest1 appended", 2, 1);
        do_ins(20, 1, 3, 1, 3);
        chk_occ("R1 duplicate index once", 3, 1);

        // R2 / R3 ordering against the head (head of r1 = 10)
        chk_rd("R2 older reader", 1, 5, 1);
        chk_rd("R2 reader equals head", 1, 10, 1);
        chk_rd("R2 younger reader stalls", 1, 11, 0);
        chk_wr("R3 writer equals head", 1, 10, 1);
        chk_wr("R3 younger writer stalls", 1, 11, 0);

        // r1 becomes 10,12,14
        do_ins(12, 1, 1, 0, 0);
        do_ins(14, 1, 1, 0, 0);
        chk_occ("R1 tail append", 1, 3);
        chk_fw("R5 not executed", 1, 13, 0, 0);

        // R5 ready one cycle after executed
        ex_valid_i = 1; ex_seq_i = 8'd12;
        tick();
        chk_fw("R5 executed but not ready", 1, 13, 0, 0);
        @(posedge clk); #1;
        chk_fw("R4 youngest older producer", 1, 13, 1, 12);
        chk_fw("R4 picks 14 not 12", 1, 20, 0, 0);
        chk_fw("R4 nothing older", 1, 10, 0, 0);

        // R8 bypass
        chk_by("R8 first executed after head", 1, 1, 12);
        do_ex(10);
        chk_by("R8 single entry", 2, 0, 0);
        chk_by("R8 head excluded", 1, 1, 12);
        @(posedge clk); #1;
        chk_fw("R5 head producer ready", 1, 11, 1, 10);

        // fill r1: 10,12,14,16
        do_ins(16, 1, 1, 0, 0);
        chk_occ("R1 fill to depth", 1, 4);
        set_ins(18, 1, 1, 1, 4); #0.2;
        chk("R10 stall on full target", int'(ins_stall_o), 1);
        tick();
        chk_occ("R10 full queue unchanged", 1, 4);
        chk_occ("R10 other target untouched", 4, 0);

        // R6 mismatching writeback ignored
        do_wb(1, 12);
        chk_occ("R6 mismatch ignored", 1, 4);

        // R10 stall uses pre-removal occupancy; R6 head pop
        set_ins(18, 1, 1, 0, 0);
        wb_valid_i = 1; wb_reg_i = 3'd1; wb_seq_i = 8'd10; #0.2;
        chk("R10 stall with same-cycle writeback", int'(ins_stall_o), 1);
        tick();
        chk_occ("R6 head removed, insert refused", 1, 3);
        chk_rd("R6 new head reads", 1, 12, 1);
        chk_rd("R6 younger still waits", 1, 13, 0);

        // R7 squash middle 14: 12,14,16 -> 12,16
        do_sq(14, 1, 1, 0, 0);
        chk_occ("R7 entry removed", 1, 2);
        chk_fw("R7 gap closed", 1, 15, 1, 12);
        chk_fw("R7 16 not executed", 1, 17, 0, 0);
        do_ex(16);
        @(posedge clk); #1;
        chk_fw("R7 order kept", 1, 17, 1, 16);
        chk_by("R7 bypass after compaction", 1, 1, 16);
        do_sq(99, 1, 1, 1, 2);
        chk_occ("R7 absent squash r1", 1, 2);
        chk_occ("R7 absent squash r2", 2, 1);

        // R9 clear overrides concurrent insert
        clear_i = 1;
        set_ins(40, 1, 5, 0, 0);
        tick();
        for (int r = 0; r < 8; r++) chk_occ("R9 clear empties", r, 0);

        // R11 wrap-aware order
        do_ins(250, 1, 6, 0, 0);
        chk_rd("R11 wrapped younger stalls", 6, 3, 0);
        chk_rd("R11 older reader", 6, 249, 1);
        chk_wr("R3 wrapped writer stalls", 6, 3, 0);
        do_ex(250);
        @(posedge clk); #1;
        chk_fw("R11 forward across wrap", 6, 3, 1, 250);
        chk_fw("R11 requester older than all", 6, 249, 0, 0);
        do_ins(2, 1, 6, 0, 0);
        chk_fw("R11 wrapped entry is younger", 6, 5, 0, 0);
        clear_i = 1;
        tick();

        // Sweep: every register fills to depth, stalls, drains in order
        for (int r = 0; r < 8; r++) begin
            for (int k = 0; k < 4; k++) begin
                do_ins(100 + k, 1, r, 0, 0);
                chk_occ("R1 sweep fill", r, k + 1);
            end
            set_ins(104, 1, r, 0, 0); #0.2;
            chk("R10 sweep stall", int'(ins_stall_o), 1);
            tick();
            for (int k = 0; k < 4; k++) begin
                chk_rd("R2 sweep head reads", r, 100 + k, 1);
                chk_rd("R2 sweep younger waits", r, 101 + k, 0);
                do_wb(r, 100 + k);
                chk_occ("R6 sweep drain", r, 3 - k);
            end
            chk_rd("R2 sweep drained", r, 200, 1);
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", nchecks, nfail);
        $finish;
    end

endmodule